// File: doc/BRIEF.md
# Entropy Collector Register Core

This block is the register-level core of a true random number generator. Four oscillator stand-ins each present a tick strobe and a raw bit. The block picks one of them, keeps every Nth bit of the chosen source, and shifts those bits into a 192-bit holding store. Software reads that store as six 32-bit words. Each word returns zero after it has been read once. Error causes from external health tests and from an internal watchdog collect in a sticky status register. That register has its own mask and a write-one-to-clear register. Its unmasked OR drives the generator interrupt.

A host-level summary register sits above the generator interrupt. It latches the generator interrupt at bit 10 and has its own mask and clear. The summary forms the host interrupt line.

Software controls collection with three writes. Writing 1 to the enable register starts a fresh collection. Writing 0 freezes collection so that parameters can be changed. Writing 1 to the soft-reset register returns the generator to idle.

Top module: `trng_regcore`

## Requirements
- R1: After reset, the registers read as follows: status 0x00, cause mask 0x1F (all five causes masked), sample count 0, watchdog limit 0, host mask 0x400, enable 0. Both interrupt outputs are low.
- R2: Sampling works as follows:
  - While enabled, a sample is taken on every Nth tick of the selected oscillator, where N is the sample count and the source index is in bits [1:0] of the select register.
  - Ticks and bits of the other oscillators are ignored.
  - A sample count of 0 takes no sample.
- R3: The first sampled bit ends up at bit 31 of word 5 and the last at bit 0 of word 0. The bits are shifted in at bit 0 of word 0. When the 192nd bit is stored, status bit 0 (entropy valid) sets.
- R4: Once the store is full, it takes no further samples, and every read of a word (offsets 0x20 + 4*k, k = 0..5) clears that word to zero. After all six words have been read, collection resumes from an empty store.
- R5: Status bits work as follows:
  - Writing 1 to a bit of the clear register (0x08) clears the matching status bit (0x00) and leaves the others unchanged.
  - A 1 in the mask register (0x04) blocks that cause.
  - `rng_irq` is the OR of status AND NOT mask.
- R6: If a cause is raised in the same cycle as a write that clears it, the status bit stays set.
- R7: While the source is enabled, each external strobe sets its status bit: autocorrelation sets bit 1, continuous test sets bit 2, and von Neumann sets bit 3. While the source is disabled, these strobes have no effect.
- R8: The watchdog works as follows:
  - Status bit 4 sets `limit` cycles after an enabling write, if the store has not filled by then.
  - The counter is frozen while the source is disabled.
  - A limit of 0 disables the watchdog.
- R9: A 0-to-1 write of the enable register (0x10) empties the holding store and restarts the sample divider and the watchdog.
- R10: Writing 1 to the soft-reset register (0x18) clears the status, the holding store and the enable bit. The sample count, the watchdog limit and the mask keep their values.
- R11: The host status bit 10 (0x40) sets in every cycle in which `rng_irq` is high. Writing 1 to bit 10 of 0x48 clears it. `host_irq` is high when host status bit 10 is set and host mask bit 10 (0x44) is clear.
- R12: Reads of unmapped offsets return zero. Reads of the write-only clear and soft-reset registers also return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; makes entropy words clear on read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| osc_tick | input | 4 | One tick strobe per oscillator source |
| osc_bit | input | 4 | Raw bit per oscillator source |
| err_autocorr | input | 1 | Autocorrelation test failure strobe |
| err_crngt | input | 1 | Continuous test failure strobe |
| err_vn | input | 1 | Von Neumann balancer error strobe |
| rng_irq | output | 1 | Generator interrupt |
| host_irq | output | 1 | Host summary interrupt |

## Verification
Raising a cause and clearing it by software can fall in the same cycle. The bench drives an autocorrelation strobe during the very cycle in which a clear write for bit 1 commits. It then expects the bit to read back as set, and a later lone clear to remove it.

A second collision occurs when the host summary is cleared while the generator interrupt is still high. The bench expects bit 10 to reappear at once. Only after the generator status has been cleared does the host clear stick.

// File: rtl/trng_pkg.sv
package trng_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    localparam logic [7:0] A_STATUS = 8'h00;
    localparam logic [7:0] A_MASK   = 8'h04;
    localparam logic [7:0] A_CLEAR  = 8'h08;
    localparam logic [7:0] A_OSC    = 8'h0C;
    localparam logic [7:0] A_EN     = 8'h10;
    localparam logic [7:0] A_SCNT   = 8'h14;
    localparam logic [7:0] A_SWRST  = 8'h18;
    localparam logic [7:0] A_WDLIM  = 8'h1C;
    localparam logic [7:0] A_EHR0   = 8'h20;
    localparam logic [7:0] A_HSTAT  = 8'h40;
    localparam logic [7:0] A_HMASK  = 8'h44;
    localparam logic [7:0] A_HCLR   = 8'h48;

    localparam int NCAUSE     = 5;
    localparam int C_VALID    = 0;
    localparam int C_AUTOCORR = 1;
    localparam int C_CRNGT    = 2;
    localparam int C_VN       = 3;
    localparam int C_WDOG     = 4;
    localparam int HOST_BIT   = 10;
endpackage

// File: rtl/trng_sampler.sv
module trng_sampler #(
    parameter int NW     = 6,
    parameter int WW     = 32,
    parameter int SCNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_i,
    input  logic                 en_i,
    input  logic                 tick_i,
    input  logic                 bit_i,
    input  logic [SCNT_W-1:0]    sample_cnt_i,
    input  logic [NW-1:0]        rd_word_i,
    output logic [NW*WW-1:0]     ehr_o,
    output logic                 full_o,
    output logic                 full_rise_o
);
    localparam int NB  = NW * WW;
    localparam int BCW = $clog2(NB + 1);

    typedef struct packed {
        logic [NB-1:0]     ehr;
        logic [BCW-1:0]    nbits;
        logic [SCNT_W-1:0] div;
        logic              full;
        logic [NW-1:0]     rdmask;
    } smp_t;

    smp_t st_d, st_q;
    logic rise_d;

    always_comb begin
        st_d   = st_q;
        rise_d = 1'b0;
        if (restart_i) begin
            st_d = '0;
        end else begin
            for (int k = 0; k < NW; k++) begin
                if (rd_word_i[k]) begin
                    st_d.ehr[k*WW +: WW] = '0;
                    if (st_q.full) st_d.rdmask[k] = 1'b1;
                end
            end
            if (st_q.full && (&(st_q.rdmask | rd_word_i))) begin
                st_d.full   = 1'b0;
                st_d.nbits  = '0;
                st_d.rdmask = '0;
                st_d.div    = '0;
            end else if (!st_q.full && en_i && tick_i && (sample_cnt_i != '0)) begin
                if (st_q.div == sample_cnt_i - SCNT_W'(1)) begin
                    st_d.div   = '0;
                    st_d.ehr   = {st_d.ehr[NB-2:0], bit_i};
                    st_d.nbits = st_q.nbits + BCW'(1);
                    if (st_q.nbits == BCW'(NB - 1)) begin
                        st_d.full = 1'b1;
                        rise_d    = 1'b1;
                    end
                end else begin
                    st_d.div = st_q.div + SCNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ehr_o       = st_q.ehr;
    assign full_o      = st_q.full;
    assign full_rise_o = rise_d;

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nbits <= BCW'(NB));

    a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !restart_i && !(&(st_q.rdmask | rd_word_i))) |=> st_q.full);

    for (genvar k = 0; k < NW; k++) begin : g_rdchk
        a_r4_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_word_i[k] && st_q.full) |=> (st_q.ehr[k*WW +: WW] == '0));
    end
endmodule

// File: rtl/trng_watchdog.sv
module trng_watchdog #(
    parameter int WD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            run_i,
    input  logic [WD_W-1:0] limit_i,
    output logic            timeout_o
);
    typedef struct packed {
        logic [WD_W-1:0] cnt;
        logic            fired;
    } wd_t;

    wd_t wd_d, wd_q;
    logic to_d;

    always_comb begin
        wd_d = wd_q;
        to_d = 1'b0;
        if (restart_i) begin
            wd_d = '0;
        end else if (run_i && !wd_q.fired && (limit_i != '0)) begin
            if (wd_q.cnt == limit_i - WD_W'(1)) begin
                wd_d.fired = 1'b1;
                to_d       = 1'b1;
            end else begin
                wd_d.cnt = wd_q.cnt + WD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign timeout_o = to_d;

    // R8: a timeout only comes from a running, armed counter
    a_r8_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (run_i && limit_i != '0 && !restart_i));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(wd_q.cnt));
endmodule

// File: rtl/trng_irq_bank.sv
module trng_irq_bank #(
    parameter int           N        = 5,
    parameter logic [N-1:0] RST_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         soft_clr_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_wdata_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] mask;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (soft_clr_i) bk_d.status = set_i;
        else            bk_d.status = (bk_q.status & ~clr_i) | set_i;
        if (mask_wr_i)  bk_d.mask   = mask_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.status <= '0;
            bk_q.mask   <= RST_MASK;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign status_o = bk_q.status;
    assign mask_o   = bk_q.mask;
    assign irq_o    = |(bk_q.status & ~bk_q.mask);

    for (genvar b = 0; b < N; b++) begin : g_chk
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> status_o[b]);
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !status_o[b]);
    end
endmodule

// File: rtl/trng_regcore.sv
module trng_regcore
    import trng_pkg::*;
#(
    parameter int NUM_OSC   = 4,
    parameter int EHR_WORDS = 6,
    parameter int SCNT_W    = 16,
    parameter int WD_W      = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [7:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    input  logic [3:0]   osc_tick,
    input  logic [3:0]   osc_bit,
    input  logic         err_autocorr,
    input  logic         err_crngt,
    input  logic         err_vn,
    output logic         rng_irq,
    output logic         host_irq
);
    localparam int OSC_W = $clog2(NUM_OSC);
    localparam int NB    = EHR_WORDS * DATA_W;

    typedef struct packed {
        logic [OSC_W-1:0]  osc_sel;
        logic              src_en;
        logic [SCNT_W-1:0] sample_cnt;
        logic [WD_W-1:0]   wd_limit;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic en_rise, swrst, restart;
    logic mask_wr, hmask_wr;
    logic [NCAUSE-1:0] clr_rng, set_rng, status, mask;
    logic hclr, hstatus, hmask;
    logic [EHR_WORDS-1:0] rd_word;
    logic [NB-1:0] ehr;
    logic full, full_rise, wd_to;

    always_comb begin
        cfg_d    = cfg_q;
        en_rise  = 1'b0;
        swrst    = 1'b0;
        mask_wr  = 1'b0;
        hmask_wr = 1'b0;
        hclr     = 1'b0;
        clr_rng  = '0;
        if (bus_wr) begin
            case (bus_addr)
                A_OSC:   cfg_d.osc_sel    = bus_wdata[OSC_W-1:0];
                A_EN: begin
                    cfg_d.src_en = bus_wdata[0];
                    en_rise      = bus_wdata[0] & ~cfg_q.src_en;
                end
                A_SCNT:  cfg_d.sample_cnt = bus_wdata[SCNT_W-1:0];
                A_WDLIM: cfg_d.wd_limit   = bus_wdata[WD_W-1:0];
                A_SWRST: swrst            = bus_wdata[0];
                A_MASK:  mask_wr          = 1'b1;
                A_CLEAR: clr_rng          = bus_wdata[NCAUSE-1:0];
                A_HMASK: hmask_wr         = 1'b1;
                A_HCLR:  hclr             = bus_wdata[HOST_BIT];
                default: ;
            endcase
        end
        if (swrst) cfg_d.src_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign restart = en_rise | swrst;

    for (genvar k = 0; k < EHR_WORDS; k++) begin : g_rd
        assign rd_word[k] = bus_rd && (bus_addr == A_EHR0 + 8'(4 * k));
    end

    trng_sampler #(.NW(EHR_WORDS), .WW(DATA_W), .SCNT_W(SCNT_W)) sampler_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart),
        .en_i         (cfg_q.src_en),
        .tick_i       (osc_tick[cfg_q.osc_sel]),
        .bit_i        (osc_bit[cfg_q.osc_sel]),
        .sample_cnt_i (cfg_q.sample_cnt),
        .rd_word_i    (rd_word),
        .ehr_o        (ehr),
        .full_o       (full),
        .full_rise_o  (full_rise)
    );

    trng_watchdog #(.WD_W(WD_W)) wdog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (cfg_q.src_en && !full),
        .limit_i   (cfg_q.wd_limit),
        .timeout_o (wd_to)
    );

    always_comb begin
        set_rng             = '0;
        set_rng[C_VALID]    = full_rise;
        set_rng[C_AUTOCORR] = err_autocorr & cfg_q.src_en;
        set_rng[C_CRNGT]    = err_crngt & cfg_q.src_en;
        set_rng[C_VN]       = err_vn & cfg_q.src_en;
        set_rng[C_WDOG]     = wd_to;
    end

    trng_irq_bank #(.N(NCAUSE), .RST_MASK('1)) rng_bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_rng),
        .clr_i        (clr_rng),
        .soft_clr_i   (swrst),
        .mask_wr_i    (mask_wr),
        .mask_wdata_i (bus_wdata[NCAUSE-1:0]),
        .status_o     (status),
        .mask_o       (mask),
        .irq_o        (rng_irq)
    );

    trng_irq_bank #(.N(1), .RST_MASK(1'b1)) host_bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (rng_irq),
        .clr_i        (hclr),
        .soft_clr_i   (1'b0),
        .mask_wr_i    (hmask_wr),
        .mask_wdata_i (bus_wdata[HOST_BIT]),
        .status_o     (hstatus),
        .mask_o       (hmask),
        .irq_o        (host_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATUS: bus_rdata = 32'(status);
            A_MASK:   bus_rdata = 32'(mask);
            A_OSC:    bus_rdata = 32'(cfg_q.osc_sel);
            A_EN:     bus_rdata = 32'(cfg_q.src_en);
            A_SCNT:   bus_rdata = 32'(cfg_q.sample_cnt);
            A_WDLIM:  bus_rdata = 32'(cfg_q.wd_limit);
            A_HSTAT:  bus_rdata = 32'(hstatus) << HOST_BIT;
            A_HMASK:  bus_rdata = 32'(hmask) << HOST_BIT;
            default: begin
                for (int k = 0; k < EHR_WORDS; k++) begin
                    if (bus_addr == A_EHR0 + 8'(4 * k)) bus_rdata = ehr[k*DATA_W +: DATA_W];
                end
            end
        endcase
    end

    // R10: soft reset drops the enable
    a_r10_swrst_disables: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> !cfg_q.src_en);

    // R11: host bit follows a raised generator interrupt
    a_r11_host_latch: assert property (@(posedge clk) disable iff (!rst_n)
        rng_irq |=> hstatus);

    // R7: disabled source ignores health strobes
    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.src_en && !status[C_AUTOCORR]) |=> !status[C_AUTOCORR]);
endmodule

// File: tb/trng_regcore_tb.sv
module trng_regcore_tb_top;
    import trng_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0] osc_tick = '0, osc_bit = '0;
    logic err_autocorr = 1'b0, err_crngt = 1'b0, err_vn = 1'b0;
    logic rng_irq, host_irq;

    int n_checks = 0;
    int n_fail = 0;
    logic [NB-1:0] model_vec;
    int model_n;
    int tick_idx;
    logic [31:0] rv;
    int unsigned seed_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    trng_regcore dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_tick(osc_tick), .osc_bit(osc_bit), .err_autocorr(err_autocorr),
        .err_crngt(err_crngt), .err_vn(err_vn), .rng_irq(rng_irq), .host_irq(host_irq)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] model_word(int k);
        return model_vec[k*32 +: 32];
    endfunction

    task automatic model_reset();
        model_vec = '0; model_n = 0; tick_idx = 0;
    endtask

    task automatic enable_fresh();
        wr(A_EN, 32'd1);
        model_reset();
    endtask

    // drive n ticks on source sel, random noise on the others
    task automatic drive_ticks(int n, int cnt, int sel);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_tick = 4'($urandom) | (4'b1 << sel);
            osc_bit  = 4'($urandom);
            if (model_n < NB && cnt != 0) begin
                tick_idx++;
                if (tick_idx % cnt == 0) begin
                    model_vec = {model_vec[NB-2:0], osc_bit[sel]};
                    model_n++;
                end
            end
        end
        @(negedge clk);
        osc_tick = '0;
    endtask

    task automatic pulse_err(logic a, logic c, logic v);
        @(negedge clk);
        err_autocorr = a; err_crngt = c; err_vn = v;
        @(negedge clk);
        err_autocorr = 1'b0; err_crngt = 1'b0; err_vn = 1'b0;
    endtask

    task automatic check_words(string req);
        for (int k = 0; k < 6; k++) begin
            rd(A_EHR0 + 8'(4*k), rv);
            check(req, rv, model_word(k));
        end
    endtask

    task automatic clean();
        wr(A_SWRST, 32'd1);
        wr(A_CLEAR, 32'h1F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd24680);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(A_STATUS, rv); check("R1 status", rv, 32'h0);
        rd(A_MASK, rv);   check("R1 mask", rv, 32'h1F);
        rd(A_HMASK, rv);  check("R1 host mask", rv, 32'h400);
        rd(A_SCNT, rv);   check("R1 sample count", rv, 32'h0);
        rd(A_WDLIM, rv);  check("R1 wd limit", rv, 32'h0);
        rd(A_EN, rv);     check("R1 enable", rv, 32'h0);
        check("R1 rng_irq", 32'(rng_irq), 32'h0);
        check("R1 host_irq", 32'(host_irq), 32'h0);

        // R12 unmapped and write-only reads
        rd(8'h3C, rv);    check("R12 unmapped 0x3C", rv, 32'h0);
        rd(8'hFC, rv);    check("R12 unmapped 0xFC", rv, 32'h0);
        rd(A_CLEAR, rv);  check("R12 clear reg", rv, 32'h0);
        rd(A_SWRST, rv);  check("R12 swrst reg", rv, 32'h0);

        // R2/R3: count 1, source 2
        wr(A_SCNT, 32'd1); wr(A_OSC, 32'd2);
        enable_fresh();
        drive_ticks(191, 1, 2);
        rd(A_STATUS, rv); check("R3 not valid at 191 bits", rv, 32'h0);
        drive_ticks(1, 1, 2);
        rd(A_STATUS, rv); check("R3 valid at 192 bits", rv, 32'h1);
        check("R5 masked valid keeps irq low", 32'(rng_irq), 32'h0);
        wr(A_MASK, 32'h1E);
        check("R5 unmasked valid raises irq", 32'(rng_irq), 32'h1);
        wr(A_CLEAR, 32'h1);
        check("R5 clear drops irq", 32'(rng_irq), 32'h0);
        wr(A_MASK, 32'h1F);
        drive_ticks(50, 1, 2); // R4 ignored while full
        check_words("R3/R4 word contents");
        for (int k = 0; k < 6; k++) begin
            rd(A_EHR0 + 8'(4*k), rv); check("R4 reread zero", rv, 32'h0);
        end
        model_reset();
        drive_ticks(192, 1, 2);
        rd(A_STATUS, rv); check("R4 refill after reads", rv, 32'h1);
        check_words("R4 refilled words");

        // R2 count 3 on source 1
        clean();
        wr(A_SCNT, 32'd3); wr(A_OSC, 32'd1);
        enable_fresh();
        drive_ticks(575, 3, 1);
        rd(A_STATUS, rv); check("R2 count 3 not yet full", rv, 32'h0);
        drive_ticks(1, 3, 1);
        rd(A_STATUS, rv); check("R2 count 3 full", rv, 32'h1);
        check_words("R2 count 3 words");

        // R2 count 0 never samples
        clean();
        wr(A_SCNT, 32'd0);
        enable_fresh();
        drive_ticks(300, 0, 1);
        rd(A_STATUS, rv); check("R2 count 0 no sample", rv, 32'h0);
        rd(A_EHR0, rv);   check("R2 count 0 word0", rv, 32'h0);

        // R9 enable rise restarts
        clean();
        wr(A_SCNT, 32'd1); wr(A_OSC, 32'd0);
        enable_fresh();
        drive_ticks(100, 1, 0);
        wr(A_EN, 32'd0);
        enable_fresh();
        drive_ticks(191, 1, 0);
        rd(A_STATUS, rv); check("R9 restart not full early", rv, 32'h0);
        drive_ticks(1, 1, 0);
        rd(A_STATUS, rv); check("R9 full after fresh 192", rv, 32'h1);

        // R10 soft reset (words are full, not read)
        wr(A_MASK, 32'h0F);
        wr(A_WDLIM, 32'd77);
        wr(A_SWRST, 32'd1);
        rd(A_STATUS, rv); check("R10 status cleared", rv, 32'h0);
        rd(A_EHR0 + 8'd20, rv); check("R10 word5 cleared", rv, 32'h0);
        rd(A_EN, rv);     check("R10 enable cleared", rv, 32'h0);
        rd(A_SCNT, rv);   check("R10 sample count kept", rv, 32'h1);
        rd(A_WDLIM, rv);  check("R10 wd limit kept", rv, 32'd77);
        rd(A_MASK, rv);   check("R10 mask kept", rv, 32'h0F);
        wr(A_WDLIM, 32'd0);
        wr(A_MASK, 32'h1F);

        // R7 strobes gated by enable
        pulse_err(1, 1, 1);
        rd(A_STATUS, rv); check("R7 disabled strobes ignored", rv, 32'h0);
        enable_fresh();
        pulse_err(1, 1, 1);
        rd(A_STATUS, rv); check("R7 enabled strobes", rv, 32'h0E);
        wr(A_CLEAR, 32'h04);
        rd(A_STATUS, rv); check("R5 selective clear", rv, 32'h0A);
        check("R5 all masked", 32'(rng_irq), 32'h0);
        wr(A_MASK, 32'h17);
        check("R5 unmask bit3", 32'(rng_irq), 32'h1);
        wr(A_MASK, 32'h1F);
        wr(A_CLEAR, 32'h1F);

        // R6 same-cycle set and clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CLEAR; bus_wdata = 32'h2; err_autocorr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; err_autocorr = 1'b0;
        rd(A_STATUS, rv); check("R6 set wins over clear", rv, 32'h2);
        wr(A_CLEAR, 32'h2);
        rd(A_STATUS, rv); check("R6 lone clear", rv, 32'h0);

        // R11 host summary
        wr(A_MASK, 32'h1D);
        pulse_err(1, 0, 0);
        check("R11 rng_irq up", 32'(rng_irq), 32'h1);
        rd(A_HSTAT, rv);  check("R11 host bit set", rv, 32'h400);
        check("R11 host masked", 32'(host_irq), 32'h0);
        wr(A_HMASK, 32'h0);
        check("R11 host unmasked", 32'(host_irq), 32'h1);
        wr(A_HCLR, 32'h400);
        rd(A_HSTAT, rv);  check("R11 host resets while rng high", rv, 32'h400);
        wr(A_CLEAR, 32'h2);
        wr(A_HCLR, 32'h400);
        rd(A_HSTAT, rv);  check("R11 host cleared", rv, 32'h0);
        check("R11 host irq low", 32'(host_irq), 32'h0);
        wr(A_HMASK, 32'h400);
        wr(A_MASK, 32'h1F);

        // R8 watchdog
        clean();
        wr(A_WDLIM, 32'd20);
        enable_fresh();
        rd(A_STATUS, rv); check("R8 not yet timed out", rv, 32'h0);
        idle(30);
        rd(A_STATUS, rv); check("R8 timeout set", rv, 32'h10);
        clean();
        enable_fresh();
        idle(5);
        wr(A_EN, 32'd0);
        idle(50);
        rd(A_STATUS, rv); check("R8 frozen while disabled", rv, 32'h0);
        clean();
        wr(A_WDLIM, 32'd0);
        enable_fresh();
        idle(100);
        rd(A_STATUS, rv); check("R8 limit 0 disabled", rv, 32'h0);

        // R5/R7 random mask and cause mix
        for (int it = 0; it < 24; it++) begin
            logic [2:0] p;
            logic [4:0] m;
            logic [4:0] exp_st;
            p = 3'($urandom);
            m = 5'($urandom);
            wr(A_CLEAR, 32'h1F);
            pulse_err(p[0], p[1], p[2]);
            wr(A_MASK, 32'(m));
            exp_st = {1'b0, p, 1'b0};
            rd(A_STATUS, rv); check("R7 random status", rv, 32'(exp_st));
            check("R5 random irq", 32'(rng_irq), 32'(|(exp_st & ~m)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule